// File: doc/BRIEF.md
# USB Suspend and Remote Wake-up Timer

This block tracks how long a USB device's bus has been idle, counted in millisecond ticks, and uses that count for two things. Once the bus has been quiet for the suspend threshold, the block raises a suspend status bit and a suspend interrupt. When the local processor asks for a remote wake-up, the block turns on the resume drive only after the bus has been idle for the longer wake-up threshold. If that threshold has already passed when the request is written, the drive turns on straight away.

The local processor writes a device state register that holds the default, address and configuration flags and the wake-up request. The same register carries a write-one bit that acknowledges the bus-reset interrupt. The interrupt pin is the OR of the interrupt status bits that the enable input allows. Line-state decoding is done upstream of this block. The electrical resume signalling is reduced to one enable output.

Top module: `usb_suspend_wake`

## Requirements
- R1: After reset the state register reads 0x01, int_status reads 0x00, and suspended, wake_req, wake_drive and irq are all low.
- R2: The idle counter advances on each ms_tick while bus_idle is high, and restarts from zero when bus_idle is low, on eop_stb, or on busrst_stb. suspended rises in the cycle after the counter has reached SUSP_MS (default 3) while the bus is still idle.
- R3: Entering suspend sets int_status bit 6. The bit clears in the same cycle that suspended falls.
- R4: suspended falls one cycle after eop_stb, resume_stb or busrst_stb.
- R5: If wake_req is set while the idle count is below WAKE_MS (default 5), wake_drive stays low until the count has reached WAKE_MS. wake_drive only ever asserts while suspended is high.
- R6: If wake_req is written while suspended and the idle count is already at WAKE_MS, wake_drive rises one cycle after wake_req is seen high.
- R7: resume_stb clears wake_req and wake_drive in the following cycle.
- R8: busrst_stb sets int_status bit 5. A write with data bit 5 set clears it, and busrst_stb wins if both happen in the same cycle. Bit 5 of the state register always reads 0.
- R9: State register layout: bit 0 is the default flag, bit 1 the address flag, bit 2 the configuration flag, bit 3 suspended (read-only), and bit 4 wake_req. Bits 0, 1, 2 and 4 take the written value. Bits 7 and 6 always read 0.
- R10: irq is high exactly when some int_status bit is high and its int_enable bit is set. Only bits 5 and 6 of int_status can ever be 1.
- R11: The idle counter saturates at WAKE_MS. After any length of idle time, a wake-up request written while suspended still drives one cycle after wake_req is seen high.
- R12: busrst_stb returns the state register to 0x01, which clears wake_req and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_idle | input | 1 | High while the bus is in the idle state |
| eop_stb | input | 1 | One-cycle pulse on any end-of-packet |
| resume_stb | input | 1 | One-cycle pulse when a resume arrives from the bus |
| busrst_stb | input | 1 | One-cycle pulse when a bus reset is detected |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| cfg_wr | input | 1 | Write strobe for the device state register |
| cfg_wdata | input | 8 | Write data for the device state register |
| int_enable | input | 8 | Per-bit interrupt enable |
| state_rd | output | 8 | Read value of the device state register |
| int_status | output | 8 | Interrupt status (bit 6 suspend, bit 5 bus reset) |
| irq | output | 1 | Interrupt request pin |
| suspended | output | 1 | Suspend status |
| wake_req | output | 1 | Remote wake-up request bit |
| wake_drive | output | 1 | Enable for resume signalling on the bus |

## Verification
The assertions assume that eop_stb, resume_stb, busrst_stb and ms_tick are one-cycle strobes. They also assume that cfg_wr is a single-cycle write with stable data. The stimulus drives every strobe for exactly one cycle from bench tasks. Long idle stretches are mixed with random activity so that the counter often reaches both thresholds. Writes of the wake-up bit land both before and after the wake-up threshold.

// File: rtl/usw_pkg.sv
package usw_pkg;
   // device state register bit positions
   localparam int unsigned ST_DFLT   = 0;
   localparam int unsigned ST_ADDR   = 1;
   localparam int unsigned ST_CFG    = 2;
   localparam int unsigned ST_SUSP   = 3;
   localparam int unsigned ST_WAKE   = 4;
   localparam int unsigned ST_RSTCLR = 5;
   // interrupt status bit positions
   localparam int unsigned IS_BUSRST = 5;
   localparam int unsigned IS_SUSP   = 6;
   localparam int unsigned REG_W     = 8;

   typedef struct packed {
      logic dflt;
      logic addr;
      logic cfg;
      logic wake;
   } state_flags_t;
endpackage

// File: rtl/usw_idle_timer.sv
module usw_idle_timer #(
   parameter int unsigned SUSP_MS = 3,
   parameter int unsigned WAKE_MS = 5,
   localparam int unsigned CNT_W  = $clog2(WAKE_MS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_idle,
   input  logic restart,
   input  logic ms_tick,
   output logic susp_hit,
   output logic wake_hit
);
   logic [CNT_W-1:0] cnt_q;
   localparam logic [CNT_W-1:0] SUSP_LIM = CNT_W'(SUSP_MS);
   localparam logic [CNT_W-1:0] WAKE_LIM = CNT_W'(WAKE_MS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!bus_idle || restart) begin
         cnt_q <= '0;
      end else if (ms_tick && (cnt_q < WAKE_LIM)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign susp_hit = (cnt_q >= SUSP_LIM);
   assign wake_hit = (cnt_q >= WAKE_LIM);
endmodule

// File: rtl/usw_state_ctrl.sv
module usw_state_ctrl
   import usw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_idle,
   input  logic              eop_stb,
   input  logic              resume_stb,
   input  logic              busrst_stb,
   input  logic              susp_hit,
   input  logic              wake_hit,
   input  logic              cfg_wr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic              susp_q,
   output logic              susp_enter,
   output logic              drive_q,
   output state_flags_t      flags_q
);
   logic leave;
   assign leave      = eop_stb | resume_stb | busrst_stb;
   assign susp_enter = !susp_q && !leave && bus_idle && susp_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         susp_q <= 1'b0;
      end else if (leave) begin
         susp_q <= 1'b0;
      end else if (susp_enter) begin
         susp_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '{dflt: 1'b1, addr: 1'b0, cfg: 1'b0, wake: 1'b0};
      end else if (busrst_stb) begin
         flags_q <= '{dflt: 1'b1, addr: 1'b0, cfg: 1'b0, wake: 1'b0};
      end else begin
         if (cfg_wr) begin
            flags_q.dflt <= cfg_wdata[ST_DFLT];
            flags_q.addr <= cfg_wdata[ST_ADDR];
            flags_q.cfg  <= cfg_wdata[ST_CFG];
            flags_q.wake <= cfg_wdata[ST_WAKE];
         end
         if (resume_stb) begin
            flags_q.wake <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drive_q <= 1'b0;
      end else if (leave) begin
         drive_q <= 1'b0;
      end else begin
         drive_q <= flags_q.wake && susp_q && (drive_q || wake_hit);
      end
   end
endmodule

// File: rtl/usw_irq_ctrl.sv
module usw_irq_ctrl
   import usw_pkg::*;
#(
   parameter bit SYNC_IRQ = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             susp_enter,
   input  logic             susp_leave,
   input  logic             busrst_stb,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic [REG_W-1:0] int_enable,
   output logic [REG_W-1:0] int_status,
   output logic             irq
);
   logic susp_int_q;
   logic rst_int_q;
   logic [REG_W-1:0] masked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         susp_int_q <= 1'b0;
      end else if (susp_leave) begin
         susp_int_q <= 1'b0;
      end else if (susp_enter) begin
         susp_int_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_int_q <= 1'b0;
      end else if (busrst_stb) begin
         rst_int_q <= 1'b1;
      end else if (cfg_wr && cfg_wdata[ST_RSTCLR]) begin
         rst_int_q <= 1'b0;
      end
   end

   for (genvar b = 0; b < REG_W; b++) begin : g_stat
      if (b == IS_SUSP) begin : g_susp
         assign int_status[b] = susp_int_q;
      end else if (b == IS_BUSRST) begin : g_rst
         assign int_status[b] = rst_int_q;
      end else begin : g_zero
         assign int_status[b] = 1'b0;
      end
      assign masked[b] = int_status[b] & int_enable[b];
   end

   if (SYNC_IRQ) begin : g_sync
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |masked;
      end
      assign irq = irq_q;
   end else begin : g_comb
      assign irq = |masked;
   end
endmodule

// File: rtl/usb_suspend_wake.sv
module usb_suspend_wake
   import usw_pkg::*;
#(
   parameter int unsigned SUSP_MS  = 3,
   parameter int unsigned WAKE_MS  = 5,
   parameter bit          SYNC_IRQ = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_idle,
   input  logic             eop_stb,
   input  logic             resume_stb,
   input  logic             busrst_stb,
   input  logic             ms_tick,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   input  logic [REG_W-1:0] int_enable,
   output logic [REG_W-1:0] state_rd,
   output logic [REG_W-1:0] int_status,
   output logic             irq,
   output logic             suspended,
   output logic             wake_req,
   output logic             wake_drive
);
   if (SUSP_MS == 0) begin : g_bad_susp
      $error("SUSP_MS must be at least one tick");
   end
   if (WAKE_MS <= SUSP_MS) begin : g_bad_wake
      $error("WAKE_MS must exceed SUSP_MS");
   end

   logic susp_hit, wake_hit, susp_q, susp_enter, drive_q, restart;
   state_flags_t flags_q;

   assign restart = eop_stb | busrst_stb;

   usw_idle_timer #(.SUSP_MS(SUSP_MS), .WAKE_MS(WAKE_MS)) timer_i (
      .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .restart(restart),
      .ms_tick(ms_tick), .susp_hit(susp_hit), .wake_hit(wake_hit)
   );

   usw_state_ctrl state_i (
      .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .eop_stb(eop_stb),
      .resume_stb(resume_stb), .busrst_stb(busrst_stb),
      .susp_hit(susp_hit), .wake_hit(wake_hit), .cfg_wr(cfg_wr),
      .cfg_wdata(cfg_wdata), .susp_q(susp_q), .susp_enter(susp_enter),
      .drive_q(drive_q), .flags_q(flags_q)
   );

   usw_irq_ctrl #(.SYNC_IRQ(SYNC_IRQ)) irq_i (
      .clk(clk), .rst_n(rst_n), .susp_enter(susp_enter),
      .susp_leave(eop_stb | resume_stb | busrst_stb),
      .busrst_stb(busrst_stb), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .int_enable(int_enable), .int_status(int_status), .irq(irq)
   );

   always_comb begin
      state_rd           = '0;
      state_rd[ST_DFLT]  = flags_q.dflt;
      state_rd[ST_ADDR]  = flags_q.addr;
      state_rd[ST_CFG]   = flags_q.cfg;
      state_rd[ST_SUSP]  = susp_q;
      state_rd[ST_WAKE]  = flags_q.wake;
   end

   assign suspended  = susp_q;
   assign wake_req   = flags_q.wake;
   assign wake_drive = drive_q;
endmodule

// File: rtl/usb_suspend_wake_chk.sv
module usb_suspend_wake_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_idle,
   input logic       eop_stb,
   input logic       resume_stb,
   input logic       busrst_stb,
   input logic [7:0] state_rd,
   input logic [7:0] int_status,
   input logic       suspended,
   input logic       wake_req,
   input logic       wake_drive
);
   AST_SUSP_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspended) |-> $past(bus_idle)); // R2
   AST_SUSP_SETS_INT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspended) |-> int_status[6]); // R3
   AST_EOP_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
      (eop_stb || resume_stb || busrst_stb) |=> !suspended); // R4
   AST_DRIVE_IN_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
      wake_drive |-> suspended); // R5
   AST_RESUME_DROPS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      resume_stb |=> (!wake_req && !wake_drive)); // R7
   AST_BUSRST_SETS_INT: assert property (@(posedge clk) disable iff (!rst_n)
      busrst_stb |=> int_status[5]); // R8
   AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      state_rd[7:5] == 3'b000); // R9
   AST_BUSRST_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      busrst_stb |=> (state_rd == 8'h01)); // R12
endmodule

bind usb_suspend_wake usb_suspend_wake_chk chk_i (
   .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .eop_stb(eop_stb),
   .resume_stb(resume_stb), .busrst_stb(busrst_stb), .state_rd(state_rd),
   .int_status(int_status), .suspended(suspended), .wake_req(wake_req),
   .wake_drive(wake_drive)
);

// File: tb/usb_suspend_wake_tb_top.sv
`timescale 1ns/1ps
module usb_suspend_wake_tb_top;
   localparam int SUSP = 3;
   localparam int WAKE = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_idle = 1'b1, eop_stb = 1'b0, resume_stb = 1'b0, busrst_stb = 1'b0;
   logic ms_tick = 1'b0, cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = '0, int_enable = '0;
   logic [7:0] state_rd, int_status;
   logic irq, suspended, wake_req, wake_drive;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   usb_suspend_wake dut_i (
      .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .eop_stb(eop_stb),
      .resume_stb(resume_stb), .busrst_stb(busrst_stb), .ms_tick(ms_tick),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .int_enable(int_enable),
      .state_rd(state_rd), .int_status(int_status), .irq(irq),
      .suspended(suspended), .wake_req(wake_req), .wake_drive(wake_drive)
   );

   // reference model state
   int  m_cnt;
   bit  m_susp, m_int6, m_int5, m_drive;
   bit  m_dflt, m_addr, m_cfg, m_wake;

   function automatic logic [7:0] exp_state();
      return {3'b000, m_wake, m_susp, m_cfg, m_addr, m_dflt};
   endfunction
   function automatic logic [7:0] exp_int();
      return {1'b0, m_int6, m_int5, 5'b0};
   endfunction
   function automatic logic exp_irq(input logic [7:0] en);
      return |(exp_int() & en);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_susp = 0; m_int6 = 0; m_int5 = 0; m_drive = 0;
         m_dflt = 1; m_addr = 0; m_cfg = 0; m_wake = 0;
      end else begin
         bit leave, enter, nd;
         int ncnt;
         leave = eop_stb | resume_stb | busrst_stb;
         enter = !m_susp && !leave && bus_idle && (m_cnt >= SUSP);
         nd = leave ? 1'b0 : (m_wake && m_susp && (m_drive || m_cnt >= WAKE));
         ncnt = (!bus_idle || eop_stb || busrst_stb) ? 0 :
                ((ms_tick && m_cnt < WAKE) ? m_cnt + 1 : m_cnt);
         if (leave) m_int6 = 0; else if (enter) m_int6 = 1;
         if (busrst_stb) m_int5 = 1; else if (cfg_wr && cfg_wdata[5]) m_int5 = 0;
         if (busrst_stb) begin
            m_dflt = 1; m_addr = 0; m_cfg = 0; m_wake = 0;
         end else begin
            if (cfg_wr) begin
               m_dflt = cfg_wdata[0]; m_addr = cfg_wdata[1];
               m_cfg = cfg_wdata[2]; m_wake = cfg_wdata[4];
            end
            if (resume_stb) m_wake = 0;
         end
         if (leave) m_susp = 0; else if (enter) m_susp = 1;
         m_drive = nd;
         m_cnt = ncnt;
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
      end
   endtask

   task automatic cmp_all();
      chk("R2 R4 suspended", {7'b0, suspended}, {7'b0, m_susp});
      chk("R9 state_rd", state_rd, exp_state());
      chk("R3 R8 int_status", int_status, exp_int());
      chk("R10 irq", {7'b0, irq}, {7'b0, exp_irq(int_enable)});
      chk("R5 R6 wake_drive", {7'b0, wake_drive}, {7'b0, m_drive});
      chk("R7 wake_req", {7'b0, wake_req}, {7'b0, m_wake});
   endtask

   // one clock: drive at negedge, compare at the next negedge
   task automatic cyc(input bit idle, input bit tick, input bit eop = 0,
                      input bit res = 0, input bit brst = 0,
                      input bit wr = 0, input logic [7:0] wd = 8'h00);
      bus_idle = idle; ms_tick = tick; eop_stb = eop; resume_stb = res;
      busrst_stb = brst; cfg_wr = wr; cfg_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      eop_stb = 0; resume_stb = 0; busrst_stb = 0; cfg_wr = 0; ms_tick = 0;
      cmp_all();
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 state_rd", state_rd, 8'h01);
      chk("R1 int_status", int_status, 8'h00);
      chk("R1 flags", {4'b0, suspended, wake_req, wake_drive, irq}, 8'h00);

      // R2: three ticks reach the threshold, suspend one cycle later
      int_enable = 8'h40;
      for (int i = 0; i < 3; i++) cyc(1, 1);
      chk("R2 not yet suspended", {7'b0, suspended}, 8'h00);
      cyc(1, 1);  // count becomes 4, suspend rises
      chk("R2 suspended", {7'b0, suspended}, 8'h01);
      chk("R3 int bit6", int_status, 8'h40);
      chk("R10 irq on suspend", {7'b0, irq}, 8'h01);
      // R5: wake written at count 4, waits for count 5
      cyc(1, 0, 0, 0, 0, 1, 8'h11);
      cyc(1, 1);
      chk("R5 drive waits", {7'b0, wake_drive}, 8'h00);
      cyc(1, 0);
      chk("R5 drive after full idle", {7'b0, wake_drive}, 8'h01);
      // R7 resume clears request and drive
      cyc(0, 0, 0, 1);
      chk("R7 wake cleared", {6'b0, wake_req, wake_drive}, 8'h00);
      chk("R4 resume leaves suspend", {7'b0, suspended}, 8'h00);
      chk("R3 int bit6 cleared", int_status, 8'h00);

      // R11 R6: long idle, counter saturates, wake drives at once
      for (int i = 0; i < 20; i++) cyc(1, 1);
      chk("R11 suspended after long idle", {7'b0, suspended}, 8'h01);
      cyc(1, 0, 0, 0, 0, 1, 8'h10);
      chk("R6 wake_req set", {7'b0, wake_req}, 8'h01);
      cyc(1, 0);
      chk("R6 R11 drive immediate", {7'b0, wake_drive}, 8'h01);
      // R4 eop leaves suspend
      cyc(1, 0, 1);
      chk("R4 eop leaves suspend", {7'b0, suspended}, 8'h00);

      // R9 write all ones
      cyc(0, 0, 0, 0, 0, 1, 8'hFF);
      chk("R9 ones masked", state_rd, 8'h17);
      // R8 R12 bus reset
      int_enable = 8'h20;
      cyc(0, 0, 0, 0, 1);
      chk("R12 state defaults", state_rd, 8'h01);
      chk("R8 int bit5 set", int_status, 8'h20);
      chk("R10 irq bus reset", {7'b0, irq}, 8'h01);
      cyc(0, 0, 0, 0, 1, 1, 8'h20);
      chk("R8 reset wins over clear", int_status, 8'h20);
      cyc(0, 0, 0, 0, 0, 1, 8'h21);
      chk("R8 cleared", int_status, 8'h00);
      chk("R8 clear bit reads zero", state_rd, 8'h01);
      chk("R10 irq dropped", {7'b0, irq}, 8'h00);

      // random phase
      for (int i = 0; i < 4000; i++) begin
         bit idle, tk, e, r, b, w;
         if (($urandom % 16) == 0) int_enable = 8'($urandom);
         idle = ($urandom % 10) != 0;
         tk   = ($urandom % 3) == 0;
         e    = ($urandom % 40) == 0;
         r    = ($urandom % 60) == 0;
         b    = ($urandom % 200) == 0;
         w    = ($urandom % 25) == 0;
         cyc(idle, tk, e, r, b, w, 8'($urandom));
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule